// File: doc/BRIEF.md
# Interleaved Configuration Image Header Parser

This block sits on a byte stream that carries several configuration images woven together in fixed-size chunks. A one-cycle start pulse picks one image (numbered from 1) and clears all parser state. The block then counts every byte it accepts. It keeps only the bytes that belong to the chosen image and drops the others.

The kept bytes must open with a fixed 13-byte signature. Tagged sections follow the signature. The parser skips sections until it reaches the data section (tag 'e'), latches that section's 32-bit length, and passes exactly that many of the image's following bytes to a downstream byte stream. If anything is wrong, the block stops parsing, raises a sticky error flag and drains the rest of the input. This covers a bad signature, an unknown tag, an oversized short length, or a header search that runs too long.

Both sides use a valid/ready handshake. Back-pressure from the payload sink stalls the input only while a payload byte is waiting. Bytes of other images keep flowing.

Top module: `bitimg_hdr_parser`

## Requirements
- R1: After reset and before the first start pulse, in_ready, out_valid, hdr_ok, found and parse_err are all 0 and pay_len is 0.
- R2: Accepted byte number i (counted from 0 after start, skipped bytes included) belongs to image k exactly when (i / CHUNK) mod N_IMG equals k-1 (default CHUNK 288, N_IMG 2). Only bytes of the image selected by img_sel are parsed or forwarded.
- R3: hdr_ok rises after the 13th selected byte when the selected bytes are 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order.
- R4: Any selected byte that differs from the signature sets parse_err. hdr_ok stays 0 and parse_err stays set until the next start.
- R5: After the signature, each section starts with a 1-byte tag. A tag below 8'h61 ('a') or above 8'h65 ('e') sets parse_err.
- R6: Tags 'a' to 'd' carry a 2-byte big-endian length, and that many content bytes are skipped. A length above 255 sets parse_err.
- R7: Tag 'e' carries a 4-byte big-endian length. After its last length byte, found rises and pay_len holds the length until the next start.
- R8: After found, exactly pay_len selected bytes appear on out_data with out_valid, in order and unchanged. A zero length forwards nothing.
- R9: While a payload byte of the selected image is offered and out_ready is 0, in_ready is 0. Bytes of other images are accepted regardless of out_ready.
- R10: Header bytes after the signature (tags, length bytes, skipped content) are counted. If the parser next expects a tag or content byte and 100 or more such bytes have been used, parse_err is set. Finding 'e' whose length ends at or past byte 100 still counts as found.
- R11: A start pulse holds in_ready at 0 for that cycle. It clears the byte counter and all flags, and relatches img_sel.
- R12: After an error or after the last payload byte, input bytes are still accepted (in_ready 1) and dropped, and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: restart and latch img_sel |
| img_sel | input | SEL_W | Selected image, 1 to N_IMG |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Payload sink ready |
| hdr_ok | output | 1 | Signature matched |
| found | output | 1 | Data section found, pay_len valid |
| parse_err | output | 1 | Sticky parse error |
| pay_len | output | 32 | Latched data section length |

## Verification
Several rules hold on every cycle and are checked continuously: the chunk owner changes only at a chunk wrap, found implies hdr_ok and never coexists with parse_err, error and length stay put until a restart, and a stalled payload byte blocks the input. Other behaviour needs whole streams, so the bench's scenarios are what show it. This covers the byte-exact de-interleaving across chunk boundaries, the signature and tag decoding, the short-length limit, the 100-byte search boundary on both sides, and the payload count. A behavioural reference replays every accepted byte each clock and predicts the flags, the length and the handshake signals.

// File: rtl/bitimg_pkg.sv
package bitimg_pkg;

    localparam int SIG_LEN   = 13;
    localparam int SIG_IDX_W = 4;

    localparam logic [7:0] TAG_FIRST = 8'h61;
    localparam logic [7:0] TAG_LAST  = 8'h65;
    localparam logic [7:0] TAG_DATA  = 8'h65;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_SIG,
        PS_TAG,
        PS_LEN,
        PS_SKIP,
        PS_PAY,
        PS_DONE,
        PS_ERR
    } pstate_e;

    function automatic logic [7:0] sig_byte(input logic [SIG_IDX_W-1:0] i);
        logic [7:0] b;
        case (i)
            4'd1:                    b = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8:  b = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9:  b = 8'hF0;
            4'd12:                   b = 8'h01;
            default:                 b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bitimg_chunk_sel.sv
module bitimg_chunk_sel #(
    parameter int CHUNK = 288,
    parameter int N_IMG = 2,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic [SEL_W-1:0] img_sel,
    output logic             hit
);
    localparam int POS_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;
    localparam int OWN_W = (N_IMG > 1) ? $clog2(N_IMG) : 1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [OWN_W-1:0] own;
        logic [OWN_W-1:0] sel;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (restart) begin
            cs_d.pos = '0;
            cs_d.own = '0;
            cs_d.sel = OWN_W'(img_sel - SEL_W'(1));
        end else if (adv) begin
            if (cs_q.pos == POS_W'(CHUNK - 1)) begin
                cs_d.pos = '0;
                cs_d.own = (cs_q.own == OWN_W'(N_IMG - 1)) ? '0 : cs_q.own + 1'b1;
            end else begin
                cs_d.pos = cs_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign hit = (cs_q.own == cs_q.sel);

    // R2: position never leaves the chunk
    a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.pos <= POS_W'(CHUNK - 1));

    // R2: owner only moves on a chunk wrap
    a_r2_own_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(adv && cs_q.pos == POS_W'(CHUNK - 1))) |=> $stable(cs_q.own));

endmodule

// File: rtl/bitimg_sec_parser.sv
module bitimg_sec_parser
    import bitimg_pkg::*;
#(
    parameter int SEARCH_MAX = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    output pstate_e     st,
    output logic        hdr_ok,
    output logic        found,
    output logic        parse_err,
    output logic [31:0] pay_len
);
    localparam int SW = $clog2(SEARCH_MAX + 8);

    typedef struct packed {
        pstate_e               st;
        logic [SIG_IDX_W-1:0]  idx;
        logic                  is_e;
        logic [31:0]           acc;
        logic [SW-1:0]         srch;
        logic [31:0]           rem;
        logic                  ok;
        logic                  fnd;
        logic                  err;
        logic [31:0]           plen;
    } ps_t;

    ps_t ps_d, ps_q;
    logic [31:0] acc_new;
    logic        last_len;

    always_comb begin
        ps_d     = ps_q;
        acc_new  = {ps_q.acc[23:0], byte_in};
        last_len = ps_q.is_e ? (ps_q.idx == SIG_IDX_W'(3)) : (ps_q.idx == SIG_IDX_W'(1));
        if (restart) begin
            ps_d    = '0;
            ps_d.st = PS_SIG;
        end else if (byte_vld) begin
            case (ps_q.st)
                PS_SIG: begin
                    if (byte_in != sig_byte(ps_q.idx)) begin
                        ps_d.st  = PS_ERR;
                        ps_d.err = 1'b1;
                    end else if (ps_q.idx == SIG_IDX_W'(SIG_LEN - 1)) begin
                        ps_d.ok   = 1'b1;
                        ps_d.st   = PS_TAG;
                        ps_d.idx  = '0;
                        ps_d.srch = '0;
                    end else begin
                        ps_d.idx = ps_q.idx + 1'b1;
                    end
                end
                PS_TAG: begin
                    ps_d.srch = ps_q.srch + 1'b1;
                    if (byte_in < TAG_FIRST || byte_in > TAG_LAST) begin
                        ps_d.st  = PS_ERR;
                        ps_d.err = 1'b1;
                    end else begin
                        ps_d.is_e = (byte_in == TAG_DATA);
                        ps_d.idx  = '0;
                        ps_d.acc  = '0;
                        ps_d.st   = PS_LEN;
                    end
                end
                PS_LEN: begin
                    ps_d.srch = ps_q.srch + 1'b1;
                    ps_d.acc  = acc_new;
                    if (!last_len) begin
                        ps_d.idx = ps_q.idx + 1'b1;
                    end else if (ps_q.is_e) begin
                        ps_d.fnd  = 1'b1;
                        ps_d.plen = acc_new;
                        ps_d.rem  = acc_new;
                        ps_d.st   = (acc_new == 32'd0) ? PS_DONE : PS_PAY;
                    end else if (acc_new > 32'd255) begin
                        ps_d.st  = PS_ERR;
                        ps_d.err = 1'b1;
                    end else begin
                        ps_d.rem = acc_new;
                        ps_d.st  = (acc_new == 32'd0) ? PS_TAG : PS_SKIP;
                    end
                end
                PS_SKIP: begin
                    ps_d.srch = ps_q.srch + 1'b1;
                    ps_d.rem  = ps_q.rem - 32'd1;
                    if (ps_q.rem == 32'd1) ps_d.st = PS_TAG;
                end
                PS_PAY: begin
                    ps_d.rem = ps_q.rem - 32'd1;
                    if (ps_q.rem == 32'd1) ps_d.st = PS_DONE;
                end
                default: ;
            endcase
            // search window: no further tag or content byte once the budget is spent
            if ((ps_d.st == PS_TAG || ps_d.st == PS_SKIP) && ps_d.srch >= SW'(SEARCH_MAX)) begin
                ps_d.st  = PS_ERR;
                ps_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign st        = ps_q.st;
    assign hdr_ok    = ps_q.ok;
    assign found     = ps_q.fnd;
    assign parse_err = ps_q.err;
    assign pay_len   = ps_q.plen;

    // R7: data section only after a good signature
    a_r7_found_after_sig: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> hdr_ok);

    // R4: error is sticky until restart
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (parse_err && !restart) |=> parse_err);

    // R7: latched length holds until restart
    a_r7_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !restart) |=> $stable(pay_len));

    // R12: found and error never coexist
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && parse_err));

    // R11: restart clears every flag
    a_r11_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!hdr_ok && !found && !parse_err));

endmodule

// File: rtl/bitimg_hdr_parser.sv
module bitimg_hdr_parser
    import bitimg_pkg::*;
#(
    parameter int CHUNK      = 288,
    parameter int N_IMG      = 2,
    parameter int SEARCH_MAX = 100,
    parameter int SEL_W      = $clog2(N_IMG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] img_sel,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             hdr_ok,
    output logic             found,
    output logic             parse_err,
    output logic [31:0]      pay_len
);
    logic    hit;
    logic    accept;
    logic    pay_phase;
    pstate_e st;

    bitimg_chunk_sel #(
        .CHUNK (CHUNK),
        .N_IMG (N_IMG),
        .SEL_W (SEL_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .adv     (accept),
        .img_sel (img_sel),
        .hit     (hit)
    );

    bitimg_sec_parser #(
        .SEARCH_MAX (SEARCH_MAX)
    ) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start),
        .byte_vld  (accept && hit),
        .byte_in   (in_data),
        .st        (st),
        .hdr_ok    (hdr_ok),
        .found     (found),
        .parse_err (parse_err),
        .pay_len   (pay_len)
    );

    assign pay_phase = (st == PS_PAY);
    assign in_ready  = !start && (st != PS_IDLE) && !(pay_phase && hit && !out_ready);
    assign accept    = in_valid && in_ready;
    assign out_valid = !start && pay_phase && hit && in_valid;
    assign out_data  = in_data;

    // R8: payload only flows after the data section is found
    a_r8_out_after_found: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> found);

    // R9: a stalled payload byte blocks the input
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1: nothing accepted before the first start
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_IDLE) |-> (!in_ready && !out_valid));

endmodule

// File: tb/bitimg_hdr_parser_test.sv
module bitimg_hdr_parser_test;
    localparam int CLK_PERIOD = 10;
    localparam int CHUNK      = 288;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  img_sel = 2'd1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        hdr_ok, found, parse_err;
    logic [31:0] pay_len;

    int checks = 0;
    int errors = 0;

    byte unsigned bld[$];
    byte unsigned img1[$];
    byte unsigned img2[$];
    byte unsigned pq[$];
    byte unsigned sq[$];
    byte unsigned got[$];
    int  total = 0;
    int  cur_sel = 1;
    bit  started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitimg_hdr_parser uut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_sel(img_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .hdr_ok(hdr_ok), .found(found), .parse_err(parse_err), .pay_len(pay_len)
    );

    task automatic chk(input bit c, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!c) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // behavioural reference over the selected bytes accepted so far
    task automatic ref_eval(output bit ok, output bit f, output bit e, output logic [31:0] l, output int fw);
        int p;
        int cnt;
        int w;
        int n;
        logic [31:0] L;
        byte unsigned sig[13] = '{8'h00,8'h09,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h00,8'h00,8'h01};
        ok = 0; f = 0; e = 0; l = 0; fw = 0;
        n = sq.size();
        for (int i = 0; i < 13; i++) begin
            if (i >= n) return;
            if (sq[i] != sig[i]) begin e = 1; return; end
        end
        ok = 1; p = 13; cnt = 0;
        forever begin
            if (cnt >= 100) begin e = 1; return; end
            if (p >= n) return;
            if (sq[p] < 8'h61 || sq[p] > 8'h65) begin e = 1; return; end
            w = (sq[p] == 8'h65) ? 4 : 2;
            p++; cnt++;
            L = 0;
            for (int j = 0; j < w; j++) begin
                if (p >= n) return;
                L = {L[23:0], sq[p][7:0]};
                p++; cnt++;
            end
            if (w == 4) begin
                f = 1; l = L;
                fw = ((n - p) < int'(L)) ? (n - p) : int'(L);
                return;
            end
            if (L > 255) begin e = 1; return; end
            for (int j = 0; j < int'(L); j++) begin
                if (cnt >= 100) begin e = 1; return; end
                if (p >= n) return;
                p++; cnt++;
            end
        end
    endtask

    function automatic byte unsigned stream_byte(input int t);
        int ch;
        int loc;
        ch  = t / CHUNK;
        loc = (ch / 2) * CHUNK + (t % CHUNK);
        if (ch % 2 == 0) return (loc < img1.size()) ? img1[loc] : 8'hEE;
        return (loc < img2.size()) ? img2[loc] : 8'hEE;
    endfunction

    task automatic cycle();
        bit ok, f, e, selb, pay, exp_rdy, exp_ov;
        logic [31:0] l;
        int fw;
        @(negedge clk);
        ref_eval(ok, f, e, l, fw);
        chk(hdr_ok == ok,    "R3 hdr_ok",    hdr_ok,    ok);
        chk(parse_err == e,  "R4 parse_err", parse_err, e);
        chk(found == f,      "R7 found",     found,     f);
        chk(pay_len == l,    "R7 pay_len",   pay_len,   l);
        start     = 1'b0;
        in_valid  = ($urandom_range(0, 7) != 0);
        out_ready = ($urandom_range(0, 3) != 0);
        in_data   = stream_byte(total);
        #1;
        selb    = ((total / CHUNK) % 2) == (cur_sel - 1);
        pay     = started && f && (fw < int'(l));
        exp_rdy = started && !(pay && selb && !out_ready);
        exp_ov  = pay && selb && in_valid;
        chk(in_ready == exp_rdy,  "R9 in_ready",  in_ready,  exp_rdy);
        chk(out_valid == exp_ov,  "R8 out_valid", out_valid, exp_ov);
        if (exp_ov) chk(out_data == in_data, "R8 out_data", out_data, in_data);
        if (out_valid && out_ready) got.push_back(out_data);
        if (in_valid && in_ready) begin
            if (selb) sq.push_back(in_data);
            total++;
        end
    endtask

    task automatic run(input int upto);
        while (total < upto) cycle();
    endtask

    task automatic start_img(input int k);
        @(negedge clk);
        start    = 1'b1;
        in_valid = 1'b0;
        img_sel  = 2'(k);
        #1;
        chk(in_ready == 1'b0, "R11 in_ready during start", in_ready, 0);
        sq.delete(); got.delete();
        total = 0; cur_sel = k; started = 1;
    endtask

    task automatic push_sig();
        byte unsigned s[13] = '{8'h00,8'h09,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h00,8'h00,8'h01};
        foreach (s[i]) bld.push_back(s[i]);
    endtask

    task automatic push_sec(input byte unsigned tag, input int len, input int w);
        bld.push_back(tag);
        for (int i = w - 1; i >= 0; i--) bld.push_back(byte'(len >> (8 * i)));
    endtask

    task automatic push_fill(input int n, input int seed);
        for (int i = 0; i < n; i++) bld.push_back(byte'(seed + 7 * i));
    endtask

    task automatic push_pay(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            bld.push_back(byte'(seed + 13 * i));
            pq.push_back(byte'(seed + 13 * i));
        end
    endtask

    task automatic new_case();
        bld.delete(); pq.delete(); img1.delete(); img2.delete();
    endtask

    task automatic expect_end(input string tag, input bit ok, input bit f, input bit e, input int len);
        @(negedge clk);
        chk(hdr_ok == ok,       {tag, " hdr_ok"},    hdr_ok,    ok);
        chk(found == f,         {tag, " found"},     found,     f);
        chk(parse_err == e,     {tag, " parse_err"}, parse_err, e);
        chk(pay_len == len,     {tag, " pay_len"},   pay_len,   len);
    endtask

    task automatic expect_payload(input string tag);
        bit same;
        same = (got.size() == pq.size());
        if (same) foreach (pq[i]) if (got[i] != pq[i]) same = 0;
        chk(got.size() == pq.size(), {tag, " payload count"}, got.size(), pq.size());
        chk(same, {tag, " payload bytes"}, same, 1);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", WD_LIMIT);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!in_ready && !hdr_ok && !found && !parse_err && pay_len == 0, "R1 reset state", in_ready, 0);
        repeat (5) cycle();
        chk(total == 0, "R1 nothing accepted before start", total, 0);

        // main: image 1, skip two sections, forward 20
        new_case();
        push_sig(); push_sec(8'h61, 3, 2); push_fill(3, 5); push_sec(8'h62, 0, 2);
        push_sec(8'h65, 20, 4); push_pay(20, 8'h40);
        img1 = bld; bld.delete(); push_fill(288, 8'h33); img2 = bld;
        start_img(1); run(600);
        expect_end("R6 R7 image1", 1, 1, 0, 20);
        expect_payload("R8 image1");

        // image 2 with payload across chunk boundaries, decoy in image 1
        new_case();
        push_sig(); push_sec(8'h65, 5, 4); push_fill(5, 9); img1 = bld; bld.delete();
        push_sig(); push_sec(8'h64, 10, 2); push_fill(10, 1);
        push_sec(8'h65, 400, 4); push_pay(400, 8'h11); img2 = bld;
        start_img(2); run(1200);
        expect_end("R2 image2", 1, 1, 0, 400);
        expect_payload("R2 image2");

        // bad signature
        new_case();
        push_sig(); bld[5] = 8'h0E; push_fill(40, 2); img1 = bld;
        start_img(1); run(300);
        expect_end("R4 bad signature", 0, 0, 1, 0);
        in_valid = 1'b1; out_ready = 1'b0; #1;
        chk(in_ready == 1'b1, "R12 drain after error", in_ready, 1);

        // unknown tag
        new_case();
        push_sig(); push_sec(8'h61, 1, 2); push_fill(1, 3); bld.push_back(8'h7A); push_fill(20, 4); img1 = bld;
        start_img(1); run(300);
        expect_end("R5 unknown tag", 1, 0, 1, 0);

        // short length above 255
        new_case();
        push_sig(); push_sec(8'h63, 256, 2); push_fill(40, 6); img1 = bld;
        start_img(1); run(300);
        expect_end("R6 long short-length", 1, 0, 1, 0);

        // search window exhausted
        new_case();
        push_sig(); push_sec(8'h61, 200, 2); push_fill(200, 7); img1 = bld;
        start_img(1); run(300);
        expect_end("R10 search limit", 1, 0, 1, 0);

        // data section whose length ends exactly at byte 100
        new_case();
        push_sig(); push_sec(8'h61, 92, 2); push_fill(92, 8);
        push_sec(8'h65, 5, 4); push_pay(5, 8'hA0); img1 = bld;
        start_img(1); run(300);
        expect_end("R10 boundary found", 1, 1, 0, 5);
        expect_payload("R10 boundary payload");

        // zero-length data section
        new_case();
        push_sig(); push_sec(8'h65, 0, 4); push_fill(30, 9); img1 = bld;
        start_img(1); run(300);
        expect_end("R8 zero length", 1, 1, 0, 0);
        chk(got.size() == 0, "R8 zero length no payload", got.size(), 0);
        in_valid = 1'b1; #1;
        chk(in_ready == 1'b1, "R12 drain after done", in_ready, 1);

        // restart mid-stream
        new_case();
        push_sig(); push_sec(8'h65, 6, 4); push_pay(6, 8'h21); img1 = bld;
        start_img(1); run(20);
        start_img(1);
        @(negedge clk);
        chk(hdr_ok == 1'b0, "R11 restart clears hdr_ok", hdr_ok, 0);
        run(300);
        expect_end("R11 after restart", 1, 1, 0, 6);
        expect_payload("R11 payload after restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule